// File: doc/BRIEF.md
# Host-to-Responder Command Mailbox

This block passes short commands from a host on a small register bus to an embedded display microcontroller. The host loads a 32-bit payload word and a 32-bit command word, then raises a notify flag. While the flag is up, the microcontroller side sees a pending interrupt and a one-cycle valid pulse. It also receives the command fields, already split into bytes, and a one-cycle strobe that names the decoded operation. When the responder has finished, it pulses its done input. That pulse alone drops the flag, and dropping the flag is the only completion signal the host sees.

The command word keeps the opcode in its lowest byte, the target pipe or controller number in the next byte and a level value in the byte above that. Three opcodes are recognised: 0x65 sets a level, 0x66 selects a pipe and 0x67 sets the backlight. A pipe number of 0xFF in a pipe-select command asks the responder to shut its function off at once. For a backlight command aimed at controller 0, the block hands the responder a ramp payload of zero, whatever the host wrote. Software that sends a pipe-select command is expected to load 0xFFFF as the ramp boundary in the payload first.

The host must poll the flag before it loads the next command. To support that poll, a step counter starts over each time the flag is raised and advances once per microsecond-sized step while the flag stays up. It stops at a limit and then reports a timeout, so software can tell that an acknowledge never arrived.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the notify flag, write-error flag, timeout flag, step count, payload and command registers are all 0, and every responder strobe is low.
- R2: With the notify flag at 0, a bus write to address 0 loads the payload register and a write to address 1 loads the command register. A read returns the addressed word on `bus_rdata` in the cycle after the read is sampled.
- R3: A bus write to address 2 with bit 0 set raises the notify flag (status bit 0 and `resp_irq`). `resp_cmd_valid` is high for exactly the first cycle in which the flag is 1.
- R4: While the notify flag is 1, writes to addresses 0 and 1 leave both registers unchanged and set the write-error flag (status bit 1), which then stays set until reset.
- R5: A host write to address 2 with bit 0 clear changes nothing. Only a `resp_done` pulse while the flag is 1 clears the flag, and `resp_done` while the flag is 0 has no effect.
- R6: In the cycle `resp_cmd_valid` is high, exactly one of `op_level` (opcode 0x65), `op_pipe` (0x66) or `op_backlight` (0x67) pulses for a known opcode, and none pulses for any other opcode. Command byte 0 is the opcode, byte 1 the pipe and byte 2 the level, and these appear on `resp_opcode`, `resp_pipe` and `resp_level`.
- R7: `pipe_shutdown` pulses together with `op_pipe` when the pipe byte is 0xFF, and never with any other opcode.
- R8: `resp_data` equals the payload register captured when the flag rises, except that it is 0 for opcode 0x67 with pipe byte 0.
- R9: Raising the flag clears the step count (read at address 3). The count then advances by one every TICK_CYCLES clocks while the flag is 1, and it holds its value after the flag clears.
- R10: The step count stops at WAIT_LIMIT, and at that point the timeout flag (status bit 2) sets. The next raising of the flag clears the timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 2 | Word address: 0 payload, 1 command, 2 control/status, 3 step count |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered read data |
| resp_irq | output | 1 | Pending-command interrupt (the notify flag) |
| resp_cmd_valid | output | 1 | One-cycle pulse when a command is posted |
| resp_done | input | 1 | Responder completion pulse; clears the notify flag |
| resp_opcode | output | 8 | Opcode byte captured at post |
| resp_pipe | output | 8 | Pipe/controller byte captured at post |
| resp_level | output | 8 | Level byte captured at post |
| resp_data | output | 32 | Payload captured at post, with the ramp forced to zero when required |
| op_level | output | 1 | Set-level command strobe |
| op_pipe | output | 1 | Pipe-select command strobe |
| op_backlight | output | 1 | Backlight command strobe |
| pipe_shutdown | output | 1 | Immediate shut-off strobe |

## Verification
A notify flag stuck high locks the host out: the next payload write is refused, and the status word shows the error bit on the very next read. A flag that drops without a done pulse lets the host overwrite a command that is still in flight. A step counter that is not cleared when a command is posted, or that keeps running after the flag clears, shows up as a wrong count on the first read after a timed wait. A decode error shows as a wrong or missing strobe in the same cycle as `resp_cmd_valid`, one clock after the posting write.

// File: rtl/mb_pkg.sv
package mb_pkg;
  localparam logic [7:0] OP_SET_LEVEL = 8'h65;
  localparam logic [7:0] OP_SET_PIPE  = 8'h66;
  localparam logic [7:0] OP_SET_BL    = 8'h67;
  localparam logic [7:0] PIPE_OFF     = 8'hFF;

  localparam logic [1:0] A_PAYLOAD = 2'd0;
  localparam logic [1:0] A_COMMAND = 2'd1;
  localparam logic [1:0] A_CTRL    = 2'd2;
  localparam logic [1:0] A_STEPS   = 2'd3;
endpackage

// File: rtl/mb_handshake.sv
module mb_handshake (
  input  logic clk,
  input  logic rst,
  input  logic host_set,
  input  logic host_payload_wr,
  input  logic resp_done,
  output logic notify_q,
  output logic post_now,
  output logic valid_q,
  output logic err_q,
  output logic payload_we
);
  assign post_now   = host_set & ~notify_q;
  assign payload_we = host_payload_wr & ~notify_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      notify_q <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      valid_q <= post_now;
      if (post_now)
        notify_q <= 1'b1;
      else if (resp_done && notify_q)
        notify_q <= 1'b0;
      if (host_payload_wr && notify_q)
        err_q <= 1'b1;
    end
  end

  p_valid_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(notify_q) |-> valid_q);
  p_clear_needs_done_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(notify_q) |-> $past(resp_done));
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    $past(err_q) |-> err_q);
endmodule

// File: rtl/mb_wait_timer.sv
module mb_wait_timer #(
  parameter int TICK_CYCLES = 100,
  parameter int WAIT_LIMIT  = 80000,
  parameter int STEP_W      = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busy,
  output logic [STEP_W-1:0] steps,
  output logic              timeout
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(TICK_CYCLES - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(WAIT_LIMIT - 1);

  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      pre     <= '0;
      steps   <= '0;
      timeout <= 1'b0;
    end else if (busy && !timeout) begin
      if (pre == PRE_LAST) begin
        pre   <= '0;
        steps <= steps + 1'b1;
        if (steps == STEP_LAST)
          timeout <= 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  p_steps_bounded_r10: assert property (@(posedge clk) disable iff (rst)
    steps <= STEP_W'(WAIT_LIMIT));
  p_timeout_at_limit_r10: assert property (@(posedge clk) disable iff (rst)
    timeout |-> steps == STEP_W'(WAIT_LIMIT));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(steps));
endmodule

// File: rtl/mb_decode.sv
module mb_decode
  import mb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] cmd,
  input  logic [31:0] payload,
  output logic [7:0]  opcode,
  output logic [7:0]  pipe,
  output logic [7:0]  level,
  output logic [31:0] data_out,
  output logic        hit_level,
  output logic        hit_pipe,
  output logic        hit_bl,
  output logic        pipe_off
);
  logic [7:0] op_in, pipe_in;
  assign op_in   = cmd[7:0];
  assign pipe_in = cmd[15:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode    <= '0;
      pipe      <= '0;
      level     <= '0;
      data_out  <= '0;
      hit_level <= 1'b0;
      hit_pipe  <= 1'b0;
      hit_bl    <= 1'b0;
      pipe_off  <= 1'b0;
    end else begin
      hit_level <= load && (op_in == OP_SET_LEVEL);
      hit_pipe  <= load && (op_in == OP_SET_PIPE);
      hit_bl    <= load && (op_in == OP_SET_BL);
      pipe_off  <= load && (op_in == OP_SET_PIPE) && (pipe_in == PIPE_OFF);
      if (load) begin
        opcode   <= op_in;
        pipe     <= pipe_in;
        level    <= cmd[23:16];
        data_out <= ((op_in == OP_SET_BL) && (pipe_in == 8'd0)) ? 32'd0 : payload;
      end
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_level, hit_pipe, hit_bl}));
  p_off_with_pipe_r7: assert property (@(posedge clk) disable iff (rst)
    pipe_off |-> hit_pipe);
endmodule

// File: rtl/mb_regs.sv
module mb_regs
  import mb_pkg::*;
#(
  parameter int STEP_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              payload_we,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  input  logic [2:0]        status,
  input  logic [STEP_W-1:0] steps,
  output logic [31:0]       payload_q,
  output logic [31:0]       cmd_q,
  output logic [31:0]       rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      payload_q <= '0;
      cmd_q     <= '0;
      rdata     <= '0;
    end else begin
      if (payload_we && addr == A_PAYLOAD) payload_q <= wdata;
      if (payload_we && addr == A_COMMAND) cmd_q     <= wdata;
      if (rd) begin
        case (addr)
          A_PAYLOAD: rdata <= payload_q;
          A_COMMAND: rdata <= cmd_q;
          A_CTRL:    rdata <= {29'd0, status};
          default:   rdata <= 32'(steps);
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mb_pkg::*;
#(
  parameter int TICK_CYCLES = 100,
  parameter int WAIT_LIMIT  = 80000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        resp_irq,
  output logic        resp_cmd_valid,
  input  logic        resp_done,
  output logic [7:0]  resp_opcode,
  output logic [7:0]  resp_pipe,
  output logic [7:0]  resp_level,
  output logic [31:0] resp_data,
  output logic        op_level,
  output logic        op_pipe,
  output logic        op_backlight,
  output logic        pipe_shutdown
);
  localparam int STEP_W = $clog2(WAIT_LIMIT + 1);

  logic notify, post_now, err, payload_we, timeout;
  logic host_set, host_payload_wr;
  logic [STEP_W-1:0] steps;
  logic [31:0] payload_q, cmd_q;

  assign host_set        = bus_wr && bus_addr == A_CTRL && bus_wdata[0];
  assign host_payload_wr = bus_wr && (bus_addr == A_PAYLOAD || bus_addr == A_COMMAND);
  assign resp_irq        = notify;

  mb_handshake u_hs (
    .clk(clk), .rst(rst), .host_set(host_set), .host_payload_wr(host_payload_wr),
    .resp_done(resp_done), .notify_q(notify), .post_now(post_now),
    .valid_q(resp_cmd_valid), .err_q(err), .payload_we(payload_we));

  mb_wait_timer #(.TICK_CYCLES(TICK_CYCLES), .WAIT_LIMIT(WAIT_LIMIT), .STEP_W(STEP_W)) u_tmr (
    .clk(clk), .rst(rst), .start(post_now), .busy(notify),
    .steps(steps), .timeout(timeout));

  mb_regs #(.STEP_W(STEP_W)) u_regs (
    .clk(clk), .rst(rst), .payload_we(payload_we), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .status({timeout, err, notify}), .steps(steps),
    .payload_q(payload_q), .cmd_q(cmd_q), .rdata(bus_rdata));

  mb_decode u_dec (
    .clk(clk), .rst(rst), .load(post_now), .cmd(cmd_q), .payload(payload_q),
    .opcode(resp_opcode), .pipe(resp_pipe), .level(resp_level), .data_out(resp_data),
    .hit_level(op_level), .hit_pipe(op_pipe), .hit_bl(op_backlight),
    .pipe_off(pipe_shutdown));

  p_frozen_while_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (notify && $past(notify)) |-> ($stable(cmd_q) && $stable(payload_q)));
  p_strobe_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (op_level || op_pipe || op_backlight) |-> resp_cmd_valid);
endmodule

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;
  localparam int TICK = 4;
  localparam int LIM  = 10;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0, resp_done = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata, resp_data;
  logic resp_irq, resp_cmd_valid, op_level, op_pipe, op_backlight, pipe_shutdown;
  logic [7:0] resp_opcode, resp_pipe, resp_level;
  int applied = 0, bad = 0;
  logic finished = 0;

  always #5 clk = ~clk;

  cmd_mailbox #(.TICK_CYCLES(TICK), .WAIT_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .resp_irq(resp_irq),
    .resp_cmd_valid(resp_cmd_valid), .resp_done(resp_done), .resp_opcode(resp_opcode),
    .resp_pipe(resp_pipe), .resp_level(resp_level), .resp_data(resp_data),
    .op_level(op_level), .op_pipe(op_pipe), .op_backlight(op_backlight),
    .pipe_shutdown(pipe_shutdown));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(posedge clk); @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk); resp_done = 1;
    @(posedge clk); @(negedge clk); resp_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'd0, resp_irq}, 0);
    chk("R1 strobes", {28'd0, op_level, op_pipe, op_backlight, pipe_shutdown}, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    rd(2'd3, v); chk("R1 steps", v, 0);
    rd(2'd0, v); chk("R1 payload", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(2'd0, 32'hCAFE_0123); wr(2'd1, 32'h0A0B_0C0D);
    rd(2'd0, v); chk("R2 payload", v, 32'hCAFE_0123);
    rd(2'd1, v); chk("R2 command", v, 32'h0A0B_0C0D);
  endtask

  task automatic t_post_and_timer();
    logic [31:0] v;
    wr(2'd1, 32'h0000_0565);
    wr(2'd2, 32'h1);
    chk("R3 valid first cycle", {31'd0, resp_cmd_valid}, 1);
    chk("R3 irq", {31'd0, resp_irq}, 1);
    @(negedge clk);
    chk("R3 valid one cycle", {31'd0, resp_cmd_valid}, 0);
    repeat (6) @(posedge clk);
    done_pulse();
    chk("R5 done clears", {31'd0, resp_irq}, 0);
    rd(2'd3, v); chk("R9 steps after 9 cycles", v, 2);
    repeat (8) @(posedge clk);
    rd(2'd3, v); chk("R9 steps hold", v, 2);
  endtask

  task automatic t_notify_rules();
    logic [31:0] v;
    wr(2'd2, 32'h0); rd(2'd2, v); chk("R5 zero write idle", v & 1, 0);
    done_pulse(); rd(2'd2, v); chk("R5 done idle", v & 1, 0);
    wr(2'd2, 32'h1);
    wr(2'd2, 32'h0); rd(2'd2, v); chk("R5 zero write busy", v & 1, 1);
    done_pulse();
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr(2'd0, 32'h11); wr(2'd1, 32'h0000_0165);
    rd(2'd2, v); chk("R4 err clear before", v & 2, 0);
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h22); wr(2'd1, 32'h33);
    rd(2'd2, v); chk("R4 err set", v & 3, 3);
    done_pulse();
    rd(2'd0, v); chk("R4 payload kept", v, 32'h11);
    rd(2'd1, v); chk("R4 command kept", v, 32'h0000_0165);
    rd(2'd2, v); chk("R4 err sticky", v & 2, 2);
  endtask

  task automatic post(logic [31:0] cmd, logic [31:0] d);
    wr(2'd0, d); wr(2'd1, cmd); wr(2'd2, 32'h1);
  endtask

  task automatic t_decode();
    logic [7:0] ops [4] = '{8'h65, 8'h66, 8'h67, 8'h12};
    for (int i = 0; i < 4; i++) begin
      post({8'h00, 8'h40, 8'h03, ops[i]}, 32'h1234_0000 + i);
      chk("R6 strobes", {29'd0, op_level, op_pipe, op_backlight},
          {29'd0, ops[i] == 8'h65, ops[i] == 8'h66, ops[i] == 8'h67});
      chk("R6 fields", {8'd0, resp_level, resp_pipe, resp_opcode}, {8'd0, 8'h40, 8'h03, ops[i]});
      chk("R8 data passes", resp_data, 32'h1234_0000 + i);
      done_pulse();
    end
  endtask

  task automatic t_shutdown();
    post(32'h0000_FF66, 32'h0000_FFFF);
    chk("R7 shutdown on pipe 255", {31'd0, pipe_shutdown}, 1);
    done_pulse();
    post(32'h0000_FF67, 32'h5);
    chk("R7 no shutdown for backlight", {31'd0, pipe_shutdown}, 0);
    done_pulse();
  endtask

  task automatic t_ramp();
    post(32'h0000_0067, 32'hABCD);
    chk("R8 ramp forced zero", resp_data, 0);
    done_pulse();
    post(32'h0000_0167, 32'hABCD);
    chk("R8 ramp kept pipe 1", resp_data, 32'hABCD);
    done_pulse();
    post(32'h0000_0065, 32'hABCD);
    chk("R8 ramp kept level op", resp_data, 32'hABCD);
    done_pulse();
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    wr(2'd2, 32'h1);
    repeat (50) @(posedge clk);
    rd(2'd3, v); chk("R10 saturate", v, LIM);
    rd(2'd2, v); chk("R10 timeout flag", v & 5, 5);
    done_pulse();
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk("R10 timeout cleared", v & 4, 0);
    done_pulse();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_regs();
    t_post_and_timer();
    t_notify_rules();
    t_busy_ignore();
    t_decode();
    t_shutdown();
    t_ramp();
    t_timeout();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule